// File: doc/BRIEF.md
# Real-Time Clock with Alarm, Ordered Shadow Copy and Watchdog

This block is a memory-mapped real-time clock. A 32-bit seconds counter advances on a once-per-second tick input. A 32-bit alarm value is compared against it. When the two become equal while the alarm is armed, the block sets a pending flag and can drive an interrupt. The counter, the alarm and two persistent configuration words live in a slow, always-on domain. Here that domain is modelled as a clock enable (`slow_en`) on the main clock.

Software writes land first in fast holding registers. They reach the slow domain one register per `slow_en` pulse, in a fixed order. A stale bitmap in the status register shows which copies are still outstanding. Software must therefore poll that bitmap before it trusts a read-back of the seconds counter.

Every register has three write aliases: plain write, bit set and bit clear. A countdown watchdog counts `slow_en` pulses and pulses `wdog_bite` when it runs out. A soft reset exists, but it is refused while the watchdog is enabled.

The block holds three state machines:

- **Copy engine.** States `SY_IDLE` and `SY_PEND`.
  - `SY_IDLE` → `SY_PEND` when a write marks a register stale.
  - `SY_PEND` → `SY_IDLE` when the last stale copy completes, or on soft reset.
- **Watchdog.** States `WD_OFF`, `WD_RUN` and `WD_BITE`.
  - `WD_OFF` → `WD_RUN` when enabled with a nonzero timeout.
  - `WD_RUN` → `WD_BITE` when a slow pulse finds the count at 1.
  - `WD_RUN` → `WD_OFF` when disabled or when the timeout is zero.
  - `WD_BITE` → `WD_RUN` while still enabled, else `WD_BITE` → `WD_OFF`.
- **Alarm detector.** A registered match flag, so that the pending flag is set only on the edge where equality begins.

Top module: `rtcs_top`

Register map. The upper address nibble selects the register. Address bits [3:2] select the alias: 0 = write, 1 = set, 2 = clear, 3 = writes are ignored. Any alias reads back the current value.

| Upper nibble | Register |
|---|---|
| 0x0 | control |
| 0x1 | status |
| 0x3 | seconds |
| 0x4 | alarm |
| 0x5 | watchdog timeout |
| 0x6 | persistent word 0 |
| 0x7 | persistent word 1 |

Field positions:

- **Control:** bit 0 alarm interrupt enable, bit 1 millisecond interrupt enable (stored only), bit 2 alarm pending, bit 4 watchdog enable, bit 31 soft reset (self-clearing).
- **Status:** bit 31 reads 1 (block present). Bits 23:16 hold the stale bitmap: slot 0 persistent 0, slot 1 persistent 1, slot 6 alarm, slot 7 seconds.
- **Persistent word 0:** bit 1 wake enable, bit 2 alarm arm, bit 7 wake flag.
- **Persistent word 1:** bit 31 watchdog reload.

## Requirements
- R1: After reset, control reads 0x0, status reads 0x8000_0000, seconds reads 0 and `irq_alarm` and `wdog_bite` are low.
- R2: A write at alias offset +0x0 stores the data, +0x4 ORs the data into the register, +0x8 clears the data's set bits; reads at any alias return the current value.
- R3: A write to persistent 0, persistent 1, alarm or seconds sets that register's stale bit (status bits 16, 17, 22, 23) and the bit stays set until the copy is done; until then a read returns the previous slow-domain value.
- R4: Each `slow_en` pulse copies exactly one stale register, always the lowest-numbered stale slot (persistent 0, persistent 1, alarm, seconds in that order), and clears its stale bit.
- R5: The seconds counter increments by one on each cycle with `sec_tick` high; a seconds copy in the same cycle takes priority and the tick is lost.
- R6: When persistent 0 bit 2 is set and seconds equals alarm, control bit 2 (pending) is set one cycle after equality begins; it is not set again while equality persists; `irq_alarm` is high exactly when pending and control bit 0 are both set.
- R7: Pending is cleared only by writing bit 2 through the clear alias; plain and set writes leave it unchanged.
- R8: When the alarm match sets pending and persistent 0 bit 1 is set, persistent 0 bit 7 is set as well; it is cleared by a clear-alias write followed by its copy.
- R9: With control bit 4 set and a nonzero timeout T, the watchdog pulses `wdog_bite` high for one cycle on the T-th `slow_en` pulse and then restarts from T; a zero timeout never bites.
- R10: The copy of persistent 1 with bit 31 set reloads the watchdog count to the timeout value.
- R11: Writing control bit 31 through any alias returns every register except the seconds counter to its reset value, clears all stale bits and stops the watchdog; it is ignored while control bit 4 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_en | input | 1 | One-cycle enable pulse standing for a slow-domain clock edge |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | AW | Register address (upper nibble register, bits 3:2 alias) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_alarm | output | 1 | Alarm interrupt |
| wdog_bite | output | 1 | One-cycle watchdog expiry pulse |

## Verification
The copy engine is driven two ways:

- **One register stale.** This shows that a read-back keeps its old value until the copy.
- **Three registers stale at once, written in reverse order.** The bitmap shrinks from its lowest slot upward with one slot per pulse, which separates in-order copying from write-order or parallel copying.

The seconds path is tried with plain ticks and with a tick that coincides with a seconds copy, which tells apart priority for the write from priority for the tick.

The alarm is matched twice:

- **Wake enable clear**, which must leave the wake flag alone.
- **Wake enable set**, which must raise the wake flag.

Both runs also check pending against plain, set and clear writes.

The watchdog is run through:

- a free countdown;
- a countdown restarted by the reload copy, where the bite must move later by the restarted count;
- a zero timeout;
- a refused and an accepted soft reset.

// File: rtl/rtcs_pkg.sv
package rtcs_pkg;
    localparam int REG_W = 32;

    typedef enum logic [3:0] {
        GRP_CTRL = 4'h0,
        GRP_STAT = 4'h1,
        GRP_SEC  = 4'h3,
        GRP_ALM  = 4'h4,
        GRP_WDG  = 4'h5,
        GRP_P0   = 4'h6,
        GRP_P1   = 4'h7
    } grp_e;

    typedef enum logic [1:0] {
        AL_WR  = 2'd0,
        AL_SET = 2'd1,
        AL_CLR = 2'd2,
        AL_RSV = 2'd3
    } alias_e;

    // control bits
    localparam int CB_AIE  = 0;
    localparam int CB_MIE  = 1;
    localparam int CB_PEND = 2;
    localparam int CB_WDEN = 4;
    localparam int CB_SRST = 31;
    // persistent 0 bits
    localparam int PB_WAKE_EN = 1;
    localparam int PB_ARM     = 2;
    localparam int PB_WAKE    = 7;
    // persistent 1 bits
    localparam int P1B_RELOAD = 31;
    // status layout
    localparam int STALE_LSB   = 16;
    localparam int PRESENT_BIT = 31;
    // stale slots (copy order)
    localparam int SL_P0  = 0;
    localparam int SL_P1  = 1;
    localparam int SL_ALM = 6;
    localparam int SL_SEC = 7;

    function automatic logic [REG_W-1:0] alias_apply(
        input logic [1:0]       als,
        input logic [REG_W-1:0] cur,
        input logic [REG_W-1:0] wd
    );
        logic [REG_W-1:0] r;
        case (als)
            AL_WR:   r = wd;
            AL_SET:  r = cur | wd;
            AL_CLR:  r = cur & ~wd;
            default: r = cur;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/rtcs_sync.sv
module rtcs_sync #(
    parameter int NSLOT = 8,
    localparam int IW   = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             slow_en,
    input  logic [NSLOT-1:0] mark,
    output logic [NSLOT-1:0] stale,
    output logic             copy_vld,
    output logic [IW-1:0]    copy_idx
);
    typedef enum logic {SY_IDLE, SY_PEND} sy_e;
    sy_e sy_q, sy_d;
    logic [NSLOT-1:0] stale_q, stale_d, done_vec;

    // lowest stale slot goes first
    always_comb begin
        copy_idx = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (stale_q[i]) copy_idx = IW'(i);
        end
    end

    // outputs
    always_comb begin
        copy_vld = 1'b0;
        unique case (sy_q)
            SY_IDLE: copy_vld = 1'b0;
            SY_PEND: copy_vld = slow_en && !clr;
        endcase
        done_vec = copy_vld ? (NSLOT'(1) << copy_idx) : '0;
        stale_d  = clr ? '0 : ((stale_q & ~done_vec) | mark);
        sy_d     = (stale_d != '0) ? SY_PEND : SY_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q    <= SY_IDLE;
            stale_q <= '0;
        end else begin
            sy_q    <= sy_d;
            stale_q <= stale_d;
        end
    end

    assign stale = stale_q;

    // R4
    lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        copy_vld |-> (stale_q[copy_idx] &&
                      ((stale_q & ((NSLOT'(1) << copy_idx) - NSLOT'(1))) == '0)));
    // R3
    stale_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && (mark != '0)) |=> ((stale_q & $past(mark)) == $past(mark)));
endmodule

// File: rtl/rtcs_alarm.sv
module rtcs_alarm #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] secs,
    input  logic [W-1:0] alm,
    input  logic         arm,
    input  logic         pend_clr,
    output logic         pend,
    output logic         hit
);
    logic match_now, match_q, pend_q;

    assign match_now = arm && (secs == alm);
    assign hit       = match_now && !match_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_q <= 1'b0;
            pend_q  <= 1'b0;
        end else if (clr) begin
            match_q <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            match_q <= match_now;
            if (hit)           pend_q <= 1'b1;
            else if (pend_clr) pend_q <= 1'b0;
        end
    end

    assign pend = pend_q;

    // R6
    pend_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(match_now));
    // R7
    pend_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !pend_clr && !clr) |=> pend_q);
endmodule

// File: rtl/rtcs_wdog.sv
module rtcs_wdog #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] tmo,
    input  logic         reload,
    input  logic         slow_en,
    output logic         bite
);
    typedef enum logic [1:0] {WD_OFF, WD_RUN, WD_BITE} wd_e;
    wd_e wd_q, wd_d;
    logic [W-1:0] cnt_q, cnt_d;

    always_comb begin
        wd_d  = wd_q;
        cnt_d = cnt_q;
        unique case (wd_q)
            WD_OFF: begin
                if (en && tmo != '0) begin
                    wd_d  = WD_RUN;
                    cnt_d = tmo;
                end
            end
            WD_RUN: begin
                if (!en || tmo == '0) begin
                    wd_d = WD_OFF;
                end else if (reload) begin
                    cnt_d = tmo;
                end else if (slow_en) begin
                    if (cnt_q <= W'(1)) wd_d = WD_BITE;
                    else                cnt_d = cnt_q - W'(1);
                end
            end
            WD_BITE: begin
                cnt_d = tmo;
                wd_d  = (en && tmo != '0) ? WD_RUN : WD_OFF;
            end
            default: wd_d = WD_OFF;
        endcase
        if (clr) begin
            wd_d  = WD_OFF;
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wd_q  <= WD_OFF;
            cnt_q <= '0;
        end else begin
            wd_q  <= wd_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        bite = 1'b0;
        unique case (wd_q)
            WD_OFF:  bite = 1'b0;
            WD_RUN:  bite = 1'b0;
            WD_BITE: bite = 1'b1;
            default: bite = 1'b0;
        endcase
    end

    // R9
    bite_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bite |=> !bite);
    // R9
    bite_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bite) |-> ($past(slow_en) && $past(en)));
endmodule

// File: rtl/rtcs_top.sv
module rtcs_top
    import rtcs_pkg::*;
#(
    parameter int AW    = 8,
    parameter int NSLOT = 8,
    localparam int IW   = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_en,
    input  logic             sec_tick,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic             irq_alarm,
    output logic             wdog_bite
);
    logic [3:0] grp;
    logic [1:0] als;
    logic       wr_ok;
    logic       wr_ctrl, wr_sec, wr_alm, wr_wdg, wr_p0, wr_p1;

    assign grp   = bus_addr[7:4];
    assign als   = bus_addr[3:2];
    assign wr_ok = bus_wr && (als != AL_RSV);

    always_comb begin
        wr_ctrl = wr_ok && (grp == GRP_CTRL);
        wr_sec  = wr_ok && (grp == GRP_SEC);
        wr_alm  = wr_ok && (grp == GRP_ALM);
        wr_wdg  = wr_ok && (grp == GRP_WDG);
        wr_p0   = wr_ok && (grp == GRP_P0);
        wr_p1   = wr_ok && (grp == GRP_P1);
    end

    // fast-domain state
    logic aie_q, mie_q, wden_q;
    logic [REG_W-1:0] tmo_q;
    logic [REG_W-1:0] h_p0_q, h_p1_q, h_alm_q, h_sec_q;
    // slow-domain state
    logic [REG_W-1:0] s_p0_q, s_p1_q, s_alm_q, s_sec_q;

    logic [NSLOT-1:0] stale, mark;
    logic             copy_vld;
    logic [IW-1:0]    copy_idx;
    logic             cp_p0, cp_p1, cp_alm, cp_sec;
    logic             pend, hit;
    logic             sr_req, sr_go, pend_clr;
    logic [REG_W-1:0] ctrl_rd, nv_ctrl, nv_wdg, nv_p0, nv_p1, nv_alm, nv_sec;

    always_comb begin
        ctrl_rd          = '0;
        ctrl_rd[CB_AIE]  = aie_q;
        ctrl_rd[CB_MIE]  = mie_q;
        ctrl_rd[CB_PEND] = pend;
        ctrl_rd[CB_WDEN] = wden_q;
    end

    // new values: set/clear act on the pending value if one is waiting
    always_comb begin
        nv_ctrl = alias_apply(als, ctrl_rd, bus_wdata);
        nv_wdg  = alias_apply(als, tmo_q, bus_wdata);
        nv_p0   = alias_apply(als, stale[SL_P0]  ? h_p0_q  : s_p0_q,  bus_wdata);
        nv_p1   = alias_apply(als, stale[SL_P1]  ? h_p1_q  : s_p1_q,  bus_wdata);
        nv_alm  = alias_apply(als, stale[SL_ALM] ? h_alm_q : s_alm_q, bus_wdata);
        nv_sec  = alias_apply(als, stale[SL_SEC] ? h_sec_q : s_sec_q, bus_wdata);
    end

    assign sr_req   = wr_ctrl && bus_wdata[CB_SRST];
    assign sr_go    = sr_req && !wden_q;
    assign pend_clr = wr_ctrl && (als == AL_CLR) && bus_wdata[CB_PEND];

    always_comb begin
        mark         = '0;
        mark[SL_P0]  = wr_p0;
        mark[SL_P1]  = wr_p1;
        mark[SL_ALM] = wr_alm;
        mark[SL_SEC] = wr_sec;
    end

    rtcs_sync #(.NSLOT(NSLOT)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (sr_go),
        .slow_en  (slow_en),
        .mark     (mark),
        .stale    (stale),
        .copy_vld (copy_vld),
        .copy_idx (copy_idx)
    );

    always_comb begin
        cp_p0  = copy_vld && (copy_idx == IW'(SL_P0));
        cp_p1  = copy_vld && (copy_idx == IW'(SL_P1));
        cp_alm = copy_vld && (copy_idx == IW'(SL_ALM));
        cp_sec = copy_vld && (copy_idx == IW'(SL_SEC));
    end

    // control and watchdog timeout
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            aie_q  <= 1'b0;
            mie_q  <= 1'b0;
            wden_q <= 1'b0;
            tmo_q  <= '0;
        end else if (sr_go) begin
            aie_q  <= 1'b0;
            mie_q  <= 1'b0;
            wden_q <= 1'b0;
            tmo_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                aie_q  <= nv_ctrl[CB_AIE];
                mie_q  <= nv_ctrl[CB_MIE];
                wden_q <= nv_ctrl[CB_WDEN];
            end
            if (wr_wdg) tmo_q <= nv_wdg;
        end
    end

    // holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_p0_q  <= '0;
            h_p1_q  <= '0;
            h_alm_q <= '0;
            h_sec_q <= '0;
        end else if (sr_go) begin
            h_p0_q  <= '0;
            h_p1_q  <= '0;
            h_alm_q <= '0;
        end else begin
            if (wr_p0)  h_p0_q  <= nv_p0;
            if (wr_p1)  h_p1_q  <= nv_p1;
            if (wr_alm) h_alm_q <= nv_alm;
            if (wr_sec) h_sec_q <= nv_sec;
        end
    end

    // slow domain: copies, seconds count, wake flag
    logic [REG_W-1:0] p0_nx;
    always_comb begin
        p0_nx = cp_p0 ? h_p0_q : s_p0_q;
        if (hit && s_p0_q[PB_WAKE_EN]) p0_nx[PB_WAKE] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_p0_q  <= '0;
            s_p1_q  <= '0;
            s_alm_q <= '0;
            s_sec_q <= '0;
        end else begin
            if (cp_sec)        s_sec_q <= h_sec_q;
            else if (sec_tick) s_sec_q <= s_sec_q + REG_W'(1);
            if (sr_go) begin
                s_p0_q  <= '0;
                s_p1_q  <= '0;
                s_alm_q <= '0;
            end else begin
                s_p0_q <= p0_nx;
                if (cp_p1)  s_p1_q  <= h_p1_q;
                if (cp_alm) s_alm_q <= h_alm_q;
            end
        end
    end

    rtcs_alarm #(.W(REG_W)) u_alarm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (sr_go),
        .secs     (s_sec_q),
        .alm      (s_alm_q),
        .arm      (s_p0_q[PB_ARM]),
        .pend_clr (pend_clr),
        .pend     (pend),
        .hit      (hit)
    );

    rtcs_wdog #(.W(REG_W)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (sr_go),
        .en      (wden_q),
        .tmo     (tmo_q),
        .reload  (cp_p1 && h_p1_q[P1B_RELOAD]),
        .slow_en (slow_en),
        .bite    (wdog_bite)
    );

    assign irq_alarm = pend && aie_q;

    always_comb begin
        bus_rdata = '0;
        case (grp)
            GRP_CTRL: bus_rdata = ctrl_rd;
            GRP_STAT: begin
                bus_rdata[PRESENT_BIT] = 1'b1;
                bus_rdata[STALE_LSB +: NSLOT] = stale;
            end
            GRP_SEC:  bus_rdata = s_sec_q;
            GRP_ALM:  bus_rdata = s_alm_q;
            GRP_WDG:  bus_rdata = tmo_q;
            GRP_P0:   bus_rdata = s_p0_q;
            GRP_P1:   bus_rdata = s_p1_q;
            default:  bus_rdata = '0;
        endcase
    end

    // R11
    srst_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_req && wden_q && !slow_en && (stale != '0)) |=> (stale != '0));
    // R5
    sec_copy_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cp_sec |=> (s_sec_q == $past(h_sec_q)));
endmodule

// File: tb/rtcs_top_tb.sv
module rtcs_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_en = 1'b0;
    logic        sec_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_alarm, wdog_bite;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rtcs_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_en   (slow_en),
        .sec_tick  (sec_tick),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_alarm (irq_alarm),
        .wdog_bite (wdog_bite)
    );

    // scoreboard queues: kind 0 = read data, 1 = irq_alarm, 2 = wdog_bite
    logic [31:0] exp_q[$];
    int          kind_q[$];
    string       name_q[$];
    event        smp_ev;

    initial begin
        forever begin
            @(smp_ev);
            #1;
            while (exp_q.size() > 0) begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic int k = kind_q.pop_front();
                automatic string nm = name_q.pop_front();
                automatic logic [31:0] a;
                if (k == 0)      a = bus_rdata;
                else if (k == 1) a = {31'b0, irq_alarm};
                else             a = {31'b0, wdog_bite};
                n_chk++;
                if (a !== e) begin
                    n_fail++;
                    $display("FAIL %s: actual 0x%08h expected 0x%08h", nm, a, e);
                end
            end
        end
    end

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic pulse(input bit s, input bit t);
        @(negedge clk);
        slow_en = s; sec_tick = t;
        @(negedge clk);
        slow_en = 1'b0; sec_tick = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string nm);
        bus_addr = a;
        exp_q.push_back(e); kind_q.push_back(0); name_q.push_back(nm);
        -> smp_ev;
        #2;
    endtask

    task automatic pin_chk(input int k, input bit e, input string nm);
        exp_q.push_back({31'b0, e}); kind_q.push_back(k); name_q.push_back(nm);
        -> smp_ev;
        #2;
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        // R1 reset state
        rd_chk(8'h00, 32'h0, "R1 ctrl");
        rd_chk(8'h10, 32'h8000_0000, "R1 status");
        rd_chk(8'h30, 32'h0, "R1 seconds");
        pin_chk(1, 1'b0, "R1 irq");
        pin_chk(2, 1'b0, "R1 bite");

        // R2 aliases
        wr(8'h00, 32'h2);
        rd_chk(8'h00, 32'h2, "R2 plain write");
        wr(8'h04, 32'h1);
        rd_chk(8'h00, 32'h3, "R2 set alias");
        wr(8'h08, 32'h2);
        rd_chk(8'h04, 32'h1, "R2 clear alias, read at +4");
        rd_chk(8'h08, 32'h1, "R2 read at +8");
        wr(8'h08, 32'h1);

        // R3 single stale register
        wr(8'h30, 32'h100);
        rd_chk(8'h10, 32'h8080_0000, "R3 seconds stale");
        rd_chk(8'h30, 32'h0, "R3 old seconds before copy");
        pulse(1, 0);
        rd_chk(8'h30, 32'h100, "R3 seconds after copy");
        rd_chk(8'h10, 32'h8000_0000, "R3 stale cleared");

        // R4 ordering, written in reverse
        wr(8'h40, 32'h105);
        wr(8'h70, 32'h1);
        wr(8'h64, 32'h4);
        rd_chk(8'h10, 32'h8043_0000, "R4 three stale");
        pulse(1, 0);
        rd_chk(8'h10, 32'h8042_0000, "R4 p0 copied first");
        rd_chk(8'h60, 32'h4, "R4 p0 value");
        rd_chk(8'h40, 32'h0, "R4 alarm still old");
        pulse(1, 0);
        rd_chk(8'h10, 32'h8040_0000, "R4 p1 copied second");
        pulse(1, 0);
        rd_chk(8'h10, 32'h8000_0000, "R4 alarm copied last");
        rd_chk(8'h40, 32'h105, "R4 alarm value");

        // R5 / R6 ticks up to alarm
        for (int i = 0; i < 5; i++) pulse(0, 1);
        rd_chk(8'h30, 32'h105, "R5 five ticks");
        idle();
        rd_chk(8'h00, 32'h4, "R6 pending set");
        pin_chk(1, 1'b0, "R6 irq masked");
        rd_chk(8'h60, 32'h4, "R8 no wake when wake enable clear");
        wr(8'h04, 32'h1);
        pin_chk(1, 1'b1, "R6 irq when enabled");
        // R7
        wr(8'h00, 32'h1);
        rd_chk(8'h00, 32'h5, "R7 plain write keeps pending");
        idle();
        wr(8'h08, 32'h4);
        rd_chk(8'h00, 32'h1, "R7 clear alias clears pending");
        idle();
        rd_chk(8'h00, 32'h1, "R6 no re-set while equal");
        pin_chk(1, 1'b0, "R7 irq low");

        // R5 copy beats tick
        wr(8'h30, 32'h200);
        pulse(1, 1);
        rd_chk(8'h30, 32'h200, "R5 copy wins over tick");
        pulse(0, 1);
        rd_chk(8'h30, 32'h201, "R5 tick after copy");

        // R8 wake flag
        wr(8'h64, 32'h2);
        pulse(1, 0);
        rd_chk(8'h60, 32'h6, "R8 wake enable copied");
        wr(8'h40, 32'h203);
        pulse(1, 0);
        pulse(0, 1);
        pulse(0, 1);
        idle();
        rd_chk(8'h60, 32'h86, "R8 wake flag set");
        rd_chk(8'h00, 32'h5, "R6 pending on second match");
        pin_chk(1, 1'b1, "R6 irq second match");
        wr(8'h08, 32'h4);
        wr(8'h68, 32'h80);
        rd_chk(8'h60, 32'h86, "R8 flag held until copy");
        pulse(1, 0);
        rd_chk(8'h60, 32'h6, "R8 flag cleared");

        // R9 watchdog
        wr(8'h50, 32'h3);
        wr(8'h04, 32'h10);
        idle();
        rd_chk(8'h00, 32'h11, "R9 ctrl enabled");
        pulse(1, 0); pin_chk(2, 1'b0, "R9 no bite after 1");
        pulse(1, 0); pin_chk(2, 1'b0, "R9 no bite after 2");
        pulse(1, 0); pin_chk(2, 1'b1, "R9 bite after 3");
        idle();      pin_chk(2, 1'b0, "R9 bite one cycle");

        // R10 reload
        pulse(1, 0);
        wr(8'h74, 32'h8000_0000);
        pulse(1, 0);
        rd_chk(8'h70, 32'h8000_0001, "R10 p1 copied");
        pulse(1, 0); pin_chk(2, 1'b0, "R10 no bite 1 after reload");
        pulse(1, 0); pin_chk(2, 1'b0, "R10 no bite 2 after reload");
        pulse(1, 0); pin_chk(2, 1'b1, "R10 bite 3 after reload");

        // R11 soft reset
        wr(8'h04, 32'h8000_0000);
        rd_chk(8'h00, 32'h11, "R11 refused while watchdog on");
        rd_chk(8'h50, 32'h3, "R11 timeout kept");
        wr(8'h08, 32'h10);
        rd_chk(8'h00, 32'h1, "R11 watchdog disabled");
        wr(8'h40, 32'h999);
        rd_chk(8'h10, 32'h8040_0000, "R11 alarm stale");
        wr(8'h04, 32'h8000_0000);
        rd_chk(8'h00, 32'h0, "R11 ctrl reset");
        rd_chk(8'h10, 32'h8000_0000, "R11 stale cleared");
        rd_chk(8'h40, 32'h0, "R11 alarm reset");
        rd_chk(8'h60, 32'h0, "R11 p0 reset");
        rd_chk(8'h50, 32'h0, "R11 timeout reset");
        rd_chk(8'h30, 32'h203, "R11 seconds kept");

        // R9 zero timeout
        wr(8'h04, 32'h10);
        idle();
        for (int i = 0; i < 3; i++) begin
            pulse(1, 0);
            pin_chk(2, 1'b0, "R9 zero timeout no bite");
        end

        idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule